// File: doc/BRIEF.md
# Serial Peripheral Interface Controller with Eight-Line Device Select

This block is an SPI engine that can act as the clock-driving end of a link or as the answering end. Software configures it through four byte-wide registers: control, status, data and device select. Every transfer moves one byte each way at the same time, most significant bit first. Clock idle level and sampling phase can be set apart from each other, so all four common clocking modes are available. As clock master it makes the serial clock from the system clock at one of four rates. For the length of each byte it pulls low one of eight active-low device-select outputs, and which one is chosen by the device-select register.

The controller watches for two faults made by software or by the system. A write to the data register while a byte is still moving is refused and flagged, and the byte already moving is not disturbed. If some other party pulls the shared select input low while this controller is master, the controller drops to answering mode at once, stops driving its clock and data outputs, releases its select lines and raises a fault flag. As the answering end it drives its return data line only while its select input is low.

Top module: `spi_ctl_top`

## Requirements
- R1: After reset, control (address 0), status (address 1) and device select (address 3) read 0, all eight select outputs are high, and the clock, master-data and slave-data output enables are low.
- R2: In master mode (control bit 7 enable = 1, bit 4 master = 1) a write to the data register (address 2) starts a transfer that shifts the written byte out on the master-data line MSB first while shifting a byte in from the return line; after the transfer the data register reads the byte received.
- R3: Control bit 3 sets the clock idle level and bit 2 the phase: phase 0 samples on the first edge of each bit and changes data on the second, phase 1 changes data on the first edge and samples on the second; the clock rests at the idle level whenever no transfer runs.
- R4: Control bits 1:0 select the master clock: 00 gives clk/4, 01 clk/8, 10 clk/16, 11 clk/32, so each clock half period lasts 2, 4, 8 or 16 system clocks.
- R5: During a master transfer exactly the select output whose index equals device-select bits 2:0 is low; it goes low in the cycle the transfer starts and returns high one cycle after the last clock edge.
- R6: Status bit 7 (transfer done) sets when eight bits have moved; it clears only when a status read is followed directly by a data register access, and a data read without that status read leaves it set.
- R7: A data write during a transfer sets status bit 6 (collision), is discarded, and the byte in flight completes unchanged; bit 6 clears together with bit 7.
- R8: If the select input goes low while enabled as master, control bit 4 clears, status bit 4 (mode fault) sets, the clock and master-data enables drop and all select outputs go high; bit 4 clears when a status read is followed directly by a control write.
- R9: In slave mode (enable = 1, master = 0) the block shifts its loaded byte out on the slave-data line and takes a byte from the master-data input, clocked by the external clock while the select input is low, in the chosen clock mode.
- R10: In slave mode the slave-data output enable is low whenever the select input is high and high while it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Register address: 0 control, 1 status, 2 data, 3 device select |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effects only) |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data for reg_sel |
| sck_i | input | 1 | Serial clock input (slave mode) |
| sck_o | output | 1 | Serial clock output (master mode) |
| sck_oe | output | 1 | Serial clock output enable |
| mosi_i | input | 1 | Master-data input (slave mode) |
| mosi_o | output | 1 | Master-data output |
| mosi_oe | output | 1 | Master-data output enable |
| miso_i | input | 1 | Return-data input (master mode) |
| miso_o | output | 1 | Slave-data output |
| miso_oe | output | 1 | Slave-data output enable |
| ss_n_i | input | 1 | Select input, active low |
| ss_n_o | output | 8 | Device-select outputs, active low |

## Verification
A wrong bit counter shows within the same byte: the select line rises after too many or too few clock edges, and the byte captured by the attached device differs from the byte written. A wrong shift register or phase choice shows in the byte read back one cycle after the select line rises. Faulty flag state shows at the next status read, and a stuck mode-fault path shows within three cycles of the select input falling, as clock and data enables that stay high.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;

  typedef enum logic [1:0] {
    RA_CTRL = 2'd0,
    RA_STAT = 2'd1,
    RA_DATA = 2'd2,
    RA_SSEL = 2'd3
  } reg_addr_e;

  // control register layout, bit 7 down to bit 0
  typedef struct packed {
    logic       en;
    logic [1:0] spare;
    logic       mstr;
    logic       cpol;
    logic       cpha;
    logic [1:0] rate;
  } ctrl_t;

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int unsigned W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end

endmodule

// File: rtl/spi_baud.sv
module spi_baud #(
  parameter int unsigned RW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          cpol,
  input  logic [RW-1:0] rate,
  output logic          sck,
  output logic          lead,
  output logic          trail
);

  // largest half period is 2^(2^RW) clocks
  localparam int unsigned CW = (1 << RW) + 1;

  logic [CW-1:0] cnt_q, cnt_d, half_m1;
  logic          sck_q, sck_d;
  logic          tick;

  assign half_m1 = (CW'(2) << rate) - CW'(1);
  assign tick    = run & (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    sck_d = sck_q;
    if (!run) begin
      cnt_d = half_m1;
      sck_d = cpol;
    end else if (tick) begin
      cnt_d = half_m1;
      sck_d = ~sck_q;
    end else begin
      cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sck_q <= sck_d;
    end
  end

  assign sck   = sck_q;
  assign lead  = tick & (sck_q == cpol);
  assign trail = tick & (sck_q != cpol);

endmodule

// File: rtl/spi_shift.sv
module spi_shift #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          cpha,
  input  logic          lead,
  input  logic          trail,
  input  logic          sdi,
  output logic [DW-1:0] sreg,
  output logic          sdo,
  output logic          last
);

  localparam int unsigned EW = $clog2(2 * DW);

  logic [DW-1:0] sr_q, sr_d;
  logic          so_q, so_d;
  logic [EW-1:0] ec_q, ec_d;
  logic          capture, launch, edge_ev;

  assign capture = cpha ? trail : lead;
  assign launch  = cpha ? lead : trail;
  assign edge_ev = lead | trail;
  assign last    = edge_ev & (ec_q == EW'(2 * DW - 1));

  always_comb begin
    sr_d = sr_q;
    so_d = so_q;
    if (load) begin
      sr_d = load_val;
      so_d = load_val[DW-1];
    end else begin
      if (capture) sr_d = {sr_q[DW-2:0], sdi};
      if (launch)  so_d = sr_q[DW-1];
    end
  end

  always_comb begin
    ec_d = ec_q;
    if (clr)          ec_d = '0;
    else if (last)    ec_d = '0;
    else if (edge_ev) ec_d = ec_q + EW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
      so_q <= 1'b0;
      ec_q <= '0;
    end else begin
      sr_q <= sr_d;
      so_q <= so_d;
      ec_q <= ec_d;
    end
  end

  assign sreg = sr_q;
  assign sdo  = so_q;

endmodule

// File: rtl/spi_ctl_top.sv
module spi_ctl_top
  import spi_ctl_pkg::*;
#(
  parameter int unsigned DW  = 8,
  parameter int unsigned NSS = 8,
  parameter int unsigned RW  = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     reg_sel,
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata,
  input  logic           sck_i,
  output logic           sck_o,
  output logic           sck_oe,
  input  logic           mosi_i,
  output logic           mosi_o,
  output logic           mosi_oe,
  input  logic           miso_i,
  output logic           miso_o,
  output logic           miso_oe,
  input  logic           ss_n_i,
  output logic [NSS-1:0] ss_n_o
);

  localparam int unsigned SW = $clog2(NSS);

  // reset: asserted at once, released on a clock edge
  logic rst_n_s;
  spi_sync #(.W(1), .RST_VAL(1'b0)) u_rst (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_n_s)
  );

  // external pins into the clock domain
  logic sck_s, mosi_s, ss_s, sck_prev_q;
  spi_sync #(.W(3), .RST_VAL(3'b001)) u_pin (
    .clk(clk), .rst_n(rst_n_s), .d({sck_i, mosi_i, ss_n_i}), .q({sck_s, mosi_s, ss_s})
  );

  ctrl_t          ctrl_q, ctrl_d;
  logic [SW-1:0]  ssel_q, ssel_d;
  logic [DW-1:0]  rx_q, rx_d;
  logic           busy_q, busy_d;
  logic           fin_q;
  logic           spif_q, spif_d, wcol_q, wcol_d, modf_q, modf_d;
  logic           seen_q, seen_d;

  logic ctrl_wr, ssel_wr, data_wr, data_acc, stat_rd, any_acc;
  logic is_mstr, is_slv, slv_act, xfer_busy, fault, wr_ok, start;
  logic m_sck, m_lead, m_trail, s_chg, s_lead, s_trail;
  logic sh_lead, sh_trail, sh_sdi, sh_clr, sh_sdo, sh_last;
  logic [DW-1:0] sh_sreg;

  assign ctrl_wr  = wr_en & (reg_sel == RA_CTRL);
  assign ssel_wr  = wr_en & (reg_sel == RA_SSEL);
  assign data_wr  = wr_en & (reg_sel == RA_DATA);
  assign data_acc = (wr_en | rd_en) & (reg_sel == RA_DATA);
  assign stat_rd  = rd_en & (reg_sel == RA_STAT);
  assign any_acc  = wr_en | rd_en;

  assign is_mstr   = ctrl_q.en & ctrl_q.mstr;
  assign is_slv    = ctrl_q.en & ~ctrl_q.mstr;
  assign slv_act   = is_slv & ~ss_s;
  assign xfer_busy = is_mstr ? busy_q : slv_act;
  assign fault     = is_mstr & ~ss_s;
  assign wr_ok     = data_wr & ~xfer_busy;
  assign start     = wr_ok & is_mstr & ~fault;

  // master clock generator
  spi_baud #(.RW(RW)) u_baud (
    .clk(clk), .rst_n(rst_n_s), .run(busy_q & is_mstr), .cpol(ctrl_q.cpol),
    .rate(ctrl_q.rate[RW-1:0]), .sck(m_sck), .lead(m_lead), .trail(m_trail)
  );

  // slave clock edges
  assign s_chg   = sck_s ^ sck_prev_q;
  assign s_lead  = slv_act & s_chg & (sck_s != ctrl_q.cpol);
  assign s_trail = slv_act & s_chg & (sck_s == ctrl_q.cpol);

  assign sh_lead  = is_mstr ? m_lead  : s_lead;
  assign sh_trail = is_mstr ? m_trail : s_trail;
  assign sh_sdi   = is_mstr ? miso_i  : mosi_s;
  assign sh_clr   = is_mstr ? ~busy_q : ~slv_act;

  spi_shift #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n_s), .clr(sh_clr), .load(wr_ok), .load_val(wdata),
    .cpha(ctrl_q.cpha), .lead(sh_lead), .trail(sh_trail), .sdi(sh_sdi),
    .sreg(sh_sreg), .sdo(sh_sdo), .last(sh_last)
  );

  // next state
  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr) ctrl_d = ctrl_t'(wdata[7:0]);
    if (fault)   ctrl_d.mstr = 1'b0;

    ssel_d = ssel_q;
    if (ssel_wr) ssel_d = wdata[SW-1:0];

    busy_d = busy_q;
    if (start)                      busy_d = 1'b1;
    if (fin_q || fault || !is_mstr) busy_d = 1'b0;

    rx_d = fin_q ? sh_sreg : rx_q;

    seen_d = seen_q;
    if (stat_rd)      seen_d = 1'b1;
    else if (any_acc) seen_d = 1'b0;

    spif_d = spif_q;
    wcol_d = wcol_q;
    modf_d = modf_q;
    if (data_acc && seen_q) begin
      spif_d = 1'b0;
      wcol_d = 1'b0;
    end
    if (ctrl_wr && seen_q)       modf_d = 1'b0;
    if (fin_q)                   spif_d = 1'b1;
    if (data_wr && xfer_busy)    wcol_d = 1'b1;
    if (fault)                   modf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ctrl_q     <= '0;
      ssel_q     <= '0;
      rx_q       <= '0;
      busy_q     <= 1'b0;
      fin_q      <= 1'b0;
      spif_q     <= 1'b0;
      wcol_q     <= 1'b0;
      modf_q     <= 1'b0;
      seen_q     <= 1'b0;
      sck_prev_q <= 1'b0;
    end else begin
      ctrl_q     <= ctrl_d;
      ssel_q     <= ssel_d;
      rx_q       <= rx_d;
      busy_q     <= busy_d;
      fin_q      <= sh_last;
      spif_q     <= spif_d;
      wcol_q     <= wcol_d;
      modf_q     <= modf_d;
      seen_q     <= seen_d;
      sck_prev_q <= sck_s;
    end
  end

  // register read mux
  always_comb begin
    case (reg_sel)
      RA_CTRL: rdata = DW'(ctrl_q);
      RA_STAT: rdata = DW'({spif_q, wcol_q, 1'b0, modf_q, 4'b0000});
      RA_DATA: rdata = rx_q;
      default: rdata = DW'(ssel_q);
    endcase
  end

  // pins
  assign sck_o   = m_sck;
  assign sck_oe  = is_mstr;
  assign mosi_o  = sh_sdo;
  assign mosi_oe = is_mstr;
  assign miso_o  = sh_sdo;
  assign miso_oe = is_slv & ~ss_n_i;

  for (genvar g = 0; g < NSS; g++) begin : g_ss
    assign ss_n_o[g] = ~(is_mstr & busy_q & (ssel_q == SW'(g)));
  end

endmodule

// File: rtl/spi_ctl_chk.sv
module spi_ctl_chk #(
  parameter int unsigned NSS = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           sck_o,
  input logic           sck_oe,
  input logic [NSS-1:0] ss_n_o,
  input logic           cpol,
  input logic           wr_en,
  input logic [1:0]     reg_sel,
  input logic           wcol,
  input logic           modf
);

  // R5: never more than one device selected
  p_one_select_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~ss_n_o) <= 1);

  // R8: a select line is only driven low by an active master
  p_select_needs_master_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(&ss_n_o) |-> sck_oe);

  // R8: while a mode fault is pending the clock driver stays off
  p_fault_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    modf |-> !sck_oe);

  // R3: idle clock sits at the chosen level
  p_idle_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_oe && (&ss_n_o) && $past(&ss_n_o) && $stable(cpol)) |-> (sck_o == cpol));

  // R4: half period is at least two system clocks
  p_min_half_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_oe && !$stable(sck_o)) |=> $stable(sck_o));

  // R7: data write during a transfer raises the collision flag
  p_collide_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == 2'd2 && !(&ss_n_o)) |=> wcol);

endmodule

bind spi_ctl_top spi_ctl_chk #(.NSS(NSS)) u_chk (
  .clk(clk), .rst_n(rst_n), .sck_o(sck_o), .sck_oe(sck_oe), .ss_n_o(ss_n_o),
  .cpol(ctrl_q.cpol), .wr_en(wr_en), .reg_sel(reg_sel), .wcol(wcol_q), .modf(modf_q)
);

// File: tb/tb_spi_ctl_top.sv
`timescale 1ns/1ps
module tb_spi_ctl_top;

  logic       clk, rst_n;
  logic [1:0] reg_sel;
  logic       wr_en, rd_en;
  logic [7:0] wdata, rdata;
  logic       sck_i, sck_o, sck_oe, mosi_i, mosi_o, mosi_oe;
  logic       miso_i, miso_o, miso_oe, ss_n_i;
  logic [7:0] ss_n_o;

  spi_ctl_top dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
    .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe), .miso_i(miso_i),
    .miso_o(miso_o), .miso_oe(miso_oe), .ss_n_i(ss_n_i), .ss_n_o(ss_n_o)
  );

  initial begin
    clk = 1'b0;
    forever #4 clk = ~clk;
  end

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_sel = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_sel = a; rd_en = 1'b1;
    #1 v = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // attached peripheral model, scoreboard of bytes it must receive
  wire  all_ss = &ss_n_o;
  logic b_cpol, b_cpha;
  logic [7:0] m_tx, m_sr;
  logic [7:0] exp_q[$];

  always @(negedge all_ss) begin
    m_sr = m_tx;
    if (!b_cpha) miso_i = m_tx[7];
  end

  always @(sck_o) begin
    if (!all_ss && sck_oe) begin
      if ((sck_o != b_cpol) ^ b_cpha) m_sr = {m_sr[6:0], mosi_o};
      else                             miso_i = m_sr[7];
    end
  end

  always @(posedge all_ss) begin
    if (exp_q.size() > 0) begin
      logic [7:0] e;
      e = exp_q.pop_front();
      chk("R2/R3 byte at device", {24'd0, m_sr}, {24'd0, e});
    end
  end

  task automatic cfg_master(input logic cp, input logic ph, input logic [1:0] rt);
    b_cpol = cp; b_cpha = ph;
    bus_wr(2'd0, {1'b1, 2'b00, 1'b1, cp, ph, rt});
    repeat (2) @(negedge clk);
    chk("R3 idle level", {31'd0, sck_o}, {31'd0, cp});
  endtask

  task automatic master_xfer(input logic [7:0] dtx, input logic [7:0] mtx,
                             input logic [2:0] sel, input logic [1:0] rt);
    logic [7:0] v;
    time t0, t1;
    bus_wr(2'd3, {5'd0, sel});
    m_tx = mtx;
    exp_q.push_back(dtx);
    bus_wr(2'd2, dtx);
    chk("R5 select line", {24'd0, ss_n_o}, {24'd0, ~(8'd1 << sel)});
    @(sck_o); t0 = $time;
    @(sck_o); t1 = $time;
    chk("R4 half period", 32'((t1 - t0) / 8), 32'(2 << rt));
    wait (all_ss);
    bus_rd(2'd1, v);
    chk("R6 done set", {31'd0, v[7]}, 32'd1);
    bus_rd(2'd2, v);
    chk("R2 byte received", {24'd0, v}, {24'd0, mtx});
    bus_rd(2'd1, v);
    chk("R6 done cleared", {24'd0, v}, 32'd0);
  endtask

  task automatic slave_xfer(input logic cp, input logic ph,
                            input logic [7:0] dtx, input logic [7:0] btx);
    logic [7:0] got, v;
    bus_wr(2'd0, {1'b1, 2'b00, 1'b0, cp, ph, 2'b00});
    sck_i = cp; mosi_i = btx[7];
    repeat (4) @(negedge clk);
    chk("R10 off while deselected", {31'd0, miso_oe}, 32'd0);
    bus_wr(2'd2, dtx);
    ss_n_i = 1'b0;
    repeat (4) @(negedge clk);
    chk("R10 on while selected", {31'd0, miso_oe}, 32'd1);
    got = '0;
    for (int i = 7; i >= 0; i--) begin
      if (!ph) begin
        repeat (10) @(negedge clk);
        got = {got[6:0], miso_o};
        sck_i = ~cp;
        repeat (10) @(negedge clk);
        sck_i = cp;
        if (i > 0) mosi_i = btx[i-1];
      end else begin
        repeat (10) @(negedge clk);
        sck_i = ~cp;
        mosi_i = btx[i];
        repeat (10) @(negedge clk);
        got = {got[6:0], miso_o};
        sck_i = cp;
      end
    end
    repeat (10) @(negedge clk);
    ss_n_i = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 off after deselect", {31'd0, miso_oe}, 32'd0);
    chk("R9 byte sent by slave", {24'd0, got}, {24'd0, dtx});
    bus_rd(2'd1, v);
    chk("R9 done set", {31'd0, v[7]}, 32'd1);
    bus_rd(2'd2, v);
    chk("R9 byte taken by slave", {24'd0, v}, {24'd0, btx});
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; reg_sel = '0; wr_en = 1'b0; rd_en = 1'b0; wdata = '0;
    sck_i = 1'b0; mosi_i = 1'b0; miso_i = 1'b0; ss_n_i = 1'b1;
    b_cpol = 1'b0; b_cpha = 1'b0; m_tx = '0; m_sr = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    bus_rd(2'd0, v); chk("R1 control", {24'd0, v}, 32'd0);
    bus_rd(2'd1, v); chk("R1 status", {24'd0, v}, 32'd0);
    bus_rd(2'd3, v); chk("R1 select reg", {24'd0, v}, 32'd0);
    chk("R1 select outs", {24'd0, ss_n_o}, 32'hFF);
    chk("R1 enables", {29'd0, sck_oe, mosi_oe, miso_oe}, 32'd0);

    // R2 R3 R4 R5 all four modes, all four rates
    cfg_master(1'b0, 1'b0, 2'd0); master_xfer(8'hA5, 8'h3C, 3'd3, 2'd0);
    cfg_master(1'b0, 1'b1, 2'd1); master_xfer(8'h81, 8'h7E, 3'd0, 2'd1);
    cfg_master(1'b1, 1'b0, 2'd2); master_xfer(8'h5A, 8'hC3, 3'd7, 2'd2);
    cfg_master(1'b1, 1'b1, 2'd3); master_xfer(8'hF0, 8'h0F, 3'd5, 2'd3);

    // R7 collision, R6 clear order
    cfg_master(1'b0, 1'b0, 2'd2);
    bus_wr(2'd3, 8'd2);
    m_tx = 8'h99;
    exp_q.push_back(8'h3C);
    bus_wr(2'd2, 8'h3C);
    repeat (6) @(negedge clk);
    bus_wr(2'd2, 8'hFF);
    wait (all_ss);
    bus_rd(2'd2, v); chk("R7 byte received intact", {24'd0, v}, 32'h99);
    bus_rd(2'd1, v); chk("R6 data read alone keeps flags", {24'd0, v}, 32'hC0);
    bus_rd(2'd2, v);
    bus_rd(2'd1, v); chk("R7 collision cleared", {24'd0, v}, 32'd0);

    // R8 mode fault
    cfg_master(1'b0, 1'b0, 2'd0);
    ss_n_i = 1'b0;
    repeat (5) @(negedge clk);
    chk("R8 drivers off", {30'd0, sck_oe, mosi_oe}, 32'd0);
    chk("R8 selects high", {24'd0, ss_n_o}, 32'hFF);
    bus_rd(2'd0, v); chk("R8 master bit cleared", {31'd0, v[4]}, 32'd0);
    ss_n_i = 1'b1;
    repeat (4) @(negedge clk);
    bus_rd(2'd1, v); chk("R8 fault flag", {24'd0, v}, 32'h10);
    bus_wr(2'd0, 8'h80);
    bus_rd(2'd1, v); chk("R8 fault cleared", {24'd0, v}, 32'd0);

    // R9 R10 slave mode
    slave_xfer(1'b0, 1'b0, 8'hA6, 8'h5B);
    slave_xfer(1'b1, 1'b1, 8'h3D, 8'hC2);

    repeat (10) @(negedge clk);
    summary();
    $finish;
  end

endmodule